// File: doc/BRIEF.md
# ASN-Tagged Fully Associative Translation Buffer

This block caches page table entries for an address translation path. Each slot holds a virtual page number tag, a physical page number, an address space number (ASN), a global flag that lets the entry match in any address space, per-privilege-mode read and write enable masks, and fault-on-read / fault-on-write flags. A lookup compares the requested page number and ASN against every slot in parallel. It returns, in the same cycle, whether a slot hit and the contents of that slot.

New entries are written at a round-robin victim pointer, so no usage history is kept. Three kinds of invalidation are offered: clear everything, drop every entry that is not global (used on an address space switch), and drop the entries that a single virtual address maps to in a given address space. A victim port shows the slot under the pointer and can step the pointer without writing, which lets a miss handler read or replace that slot. Permission checking and fault generation are left to the logic that uses the lookup result.

Top module: `asn_tlb`

## Requirements
- R1: While `rst_n` is low at a clock edge, every slot becomes invalid and the victim pointer becomes 0. After reset, no lookup hits, `vic_ptr` is 0 and `vic_valid` is 0.
- R2: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is 1 or whose stored ASN equals `lk_asn`. The hit and the matched slot's fields appear combinationally from the stored state. On a miss, `lk_idx` and every field output are 0.
- R3: When `ins_en` is 1 and no flush is requested, the next edge overwrites the slot at `vic_ptr`, even if that slot is valid. The slot's tag becomes `ins_vaddr[VA_W-1:PAGE_SHIFT]`, the slot is marked valid, and the pointer moves up by one.
- R4: `fl_all` invalidates every slot and clears every field at the next edge, and resets the victim pointer to 0.
- R5: `fl_proc` invalidates every slot whose global flag is 0 at the next edge. Global slots stay intact.
- R6: `fl_addr` invalidates every valid slot whose tag equals `fl_vaddr[VA_W-1:PAGE_SHIFT]` and whose global flag is 1 or whose ASN equals `fl_asn`. All other slots stay intact.
- R7: The victim outputs always show the slot at `vic_ptr`. With no insert and no flush, `vic_adv` = 1 moves the pointer up by one and `vic_adv` = 0 holds it. An insert together with `vic_adv` moves the pointer by one only.
- R8: The victim pointer stays below ENTRIES and wraps from ENTRIES-1 to 0.
- R9: When several valid slots match a lookup, the lowest-index slot is reported.
- R10: If any flush is requested in a cycle, a simultaneous insert is dropped and the pointer does not step. `fl_all` takes precedence over every other request.
- R11: `fl_proc` and `fl_addr` asserted in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the matched slot |
| lk_ppn | output | PPN_W | Matched physical page number |
| lk_rd_en | output | MODES | Matched per-mode read enables |
| lk_wr_en | output | MODES | Matched per-mode write enables |
| lk_fault_rd | output | 1 | Matched fault-on-read flag |
| lk_fault_wr | output | 1 | Matched fault-on-write flag |
| lk_global | output | 1 | Matched global flag |
| ins_en | input | 1 | Insert request |
| ins_vaddr | input | VA_W | Virtual address whose page becomes the tag |
| ins_ppn | input | PPN_W | Physical page number to store |
| ins_asn | input | ASN_W | ASN to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_en | input | MODES | Read enables to store |
| ins_wr_en | input | MODES | Write enables to store |
| ins_fault_rd | input | 1 | Fault-on-read flag to store |
| ins_fault_wr | input | 1 | Fault-on-write flag to store |
| fl_all | input | 1 | Invalidate all slots, reset pointer |
| fl_proc | input | 1 | Invalidate all non-global slots |
| fl_addr | input | 1 | Invalidate slots matching one address |
| fl_vaddr | input | VA_W | Address for the single-address flush |
| fl_asn | input | ASN_W | ASN for the single-address flush |
| vic_adv | input | 1 | Step the victim pointer |
| vic_ptr | output | IDX_W | Victim pointer |
| vic_valid | output | 1 | Valid flag of the victim slot |
| vic_vpn | output | VPN_W | Tag of the victim slot |
| vic_ppn | output | PPN_W | Physical page of the victim slot |
| vic_asn | output | ASN_W | ASN of the victim slot |
| vic_global | output | 1 | Global flag of the victim slot |

## Verification
The bench builds the block with 6 slots, a 20-bit virtual address with 8 offset bits, a 4-bit ASN and a 10-bit physical page. With only 6 slots, a few inserts wrap the pointer at a count that is not a power of two and overwrite valid slots. Drawing random page numbers from only eight values makes duplicate tags, global/ASN overlaps and multi-slot matches frequent. Flushes of all three kinds are mixed with same-cycle inserts and pointer steps.

// File: rtl/tlb_pkg.sv
// Shared types for the ASN-tagged translation buffer.
// Assumes: requests are decoded once per cycle into a single winning operation.
package tlb_pkg;

    // Winning operation of a cycle, ordered by precedence (highest last).
    typedef enum logic [1:0] {
        TLB_OP_NONE,
        TLB_OP_INSERT,
        TLB_OP_SEL_FLUSH,
        TLB_OP_FLUSH_ALL
    } tlb_op_e;

    // Resolve simultaneous requests: clear-all beats selective flush beats insert.
    function automatic tlb_op_e tlb_pick_op(input logic flush_all,
                                            input logic flush_sel,
                                            input logic insert);
        if (flush_all)      return TLB_OP_FLUSH_ALL;
        else if (flush_sel) return TLB_OP_SEL_FLUSH;
        else if (insert)    return TLB_OP_INSERT;
        else                return TLB_OP_NONE;
    endfunction

endpackage

// File: rtl/tlb_match_row.sv
// One slot comparator: decides whether a stored entry answers a
// (page number, address space) query. Purely combinational.
// Assumes: a global entry matches every address space.
module tlb_match_row #(
    parameter int VPN_W = 30,
    parameter int ASN_W = 8
) (
    input  logic             slot_valid,
    input  logic [VPN_W-1:0] slot_tag,
    input  logic [ASN_W-1:0] slot_asn,
    input  logic             slot_global,
    input  logic [VPN_W-1:0] query_vpn,
    input  logic [ASN_W-1:0] query_asn,
    output logic             match
);

    // Tag equality plus either the global flag or an ASN equality.
    always_comb begin
        match = slot_valid && (slot_tag == query_vpn) &&
                (slot_global || (slot_asn == query_asn));
    end

endmodule

// File: rtl/tlb_first_set.sv
// Lowest-index-first priority encoder over the per-slot match vector.
// Assumes: N >= 2; idx is 0 when no request bit is set.
module tlb_first_set #(
    parameter int N     = 48,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim_ptr.sv
// Round-robin replacement pointer with wrap at an arbitrary slot count.
// Assumes: clear has precedence over step; synchronous active-low reset.
module tlb_victim_ptr #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    // Hold, step with wrap, or return to slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/asn_tlb.sv
// Fully associative translation buffer with ASN tags and global entries.
// Lookup is combinational from the registered slot array; insert and
// flushes take effect at the next clock edge. Replacement is round-robin.
// Assumes: ENTRIES >= 2, PAGE_SHIFT < VA_W; synchronous active-low reset.
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES    = 48,
    parameter int VA_W       = 43,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 28,
    parameter int ASN_W      = 8,
    parameter int MODES      = 4,
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr,
    output logic             lk_global,
    input  logic             ins_en,
    input  logic [VA_W-1:0]  ins_vaddr,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_global,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr,
    input  logic             fl_all,
    input  logic             fl_proc,
    input  logic             fl_addr,
    input  logic [VA_W-1:0]  fl_vaddr,
    input  logic [ASN_W-1:0] fl_asn,
    input  logic             vic_adv,
    output logic [IDX_W-1:0] vic_ptr,
    output logic             vic_valid,
    output logic [VPN_W-1:0] vic_vpn,
    output logic [PPN_W-1:0] vic_ppn,
    output logic [ASN_W-1:0] vic_asn,
    output logic             vic_global
);

    // Slot storage, one array per field.
    logic             valid_q  [ENTRIES];
    logic [VPN_W-1:0] tag_q    [ENTRIES];
    logic [PPN_W-1:0] ppn_q    [ENTRIES];
    logic [ASN_W-1:0] asn_q    [ENTRIES];
    logic             glob_q   [ENTRIES];
    logic [MODES-1:0] rd_en_q  [ENTRIES];
    logic [MODES-1:0] wr_en_q  [ENTRIES];
    logic             frd_q    [ENTRIES];
    logic             fwr_q    [ENTRIES];

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_sel;
    logic [IDX_W-1:0]   ptr;
    tlb_op_e            op;
    logic               ptr_step;

    logic [VPN_W-1:0] ins_vpn;
    logic [VPN_W-1:0] fl_vpn;
    assign ins_vpn = ins_vaddr[VA_W-1:PAGE_SHIFT];
    assign fl_vpn  = fl_vaddr[VA_W-1:PAGE_SHIFT];

    // Decide which single operation wins this cycle.
    always_comb begin
        op = tlb_pick_op(fl_all, fl_proc || fl_addr, ins_en);
    end

    // Pointer steps on an insert, or on a bare advance request in an idle cycle.
    always_comb begin
        ptr_step = (op == TLB_OP_INSERT) || ((op == TLB_OP_NONE) && vic_adv);
    end

    // Two comparators per slot: one for lookups, one for address flushes.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        tlb_match_row #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_row (
            .slot_valid  (valid_q[e]),
            .slot_tag    (tag_q[e]),
            .slot_asn    (asn_q[e]),
            .slot_global (glob_q[e]),
            .query_vpn   (lk_vpn),
            .query_asn   (lk_asn),
            .match       (lk_match[e])
        );
        tlb_match_row #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_row (
            .slot_valid  (valid_q[e]),
            .slot_tag    (tag_q[e]),
            .slot_asn    (asn_q[e]),
            .slot_global (glob_q[e]),
            .query_vpn   (fl_vpn),
            .query_asn   (fl_asn),
            .match       (fl_match[e])
        );
    end

    tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
        .req (lk_match),
        .any (lk_any),
        .idx (lk_sel)
    );

    tlb_victim_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (op == TLB_OP_FLUSH_ALL),
        .step  (ptr_step),
        .ptr   (ptr)
    );

    // Per-slot update: clear, selective invalidate, or write at the victim slot.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n || (op == TLB_OP_FLUSH_ALL)) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
                ppn_q[e]   <= '0;
                asn_q[e]   <= '0;
                glob_q[e]  <= 1'b0;
                rd_en_q[e] <= '0;
                wr_en_q[e] <= '0;
                frd_q[e]   <= 1'b0;
                fwr_q[e]   <= 1'b0;
            end else if (op == TLB_OP_SEL_FLUSH) begin
                if ((fl_proc && !glob_q[e]) || (fl_addr && fl_match[e])) begin
                    valid_q[e] <= 1'b0;
                end
            end else if ((op == TLB_OP_INSERT) && (ptr == IDX_W'(e))) begin
                valid_q[e] <= 1'b1;
                tag_q[e]   <= ins_vpn;
                ppn_q[e]   <= ins_ppn;
                asn_q[e]   <= ins_asn;
                glob_q[e]  <= ins_global;
                rd_en_q[e] <= ins_rd_en;
                wr_en_q[e] <= ins_wr_en;
                frd_q[e]   <= ins_fault_rd;
                fwr_q[e]   <= ins_fault_wr;
            end
        end
    end

    // Lookup result: fields of the winning slot, forced to zero on a miss.
    always_comb begin
        lk_hit      = lk_any;
        lk_idx      = lk_any ? lk_sel : '0;
        lk_ppn      = lk_any ? ppn_q[lk_sel]   : '0;
        lk_rd_en    = lk_any ? rd_en_q[lk_sel] : '0;
        lk_wr_en    = lk_any ? wr_en_q[lk_sel] : '0;
        lk_fault_rd = lk_any && frd_q[lk_sel];
        lk_fault_wr = lk_any && fwr_q[lk_sel];
        lk_global   = lk_any && glob_q[lk_sel];
    end

    // Victim view: the slot under the replacement pointer.
    always_comb begin
        vic_ptr    = ptr;
        vic_valid  = valid_q[ptr];
        vic_vpn    = tag_q[ptr];
        vic_ppn    = ppn_q[ptr];
        vic_asn    = asn_q[ptr];
        vic_global = glob_q[ptr];
    end

endmodule

// File: rtl/tlb_checker.sv
// Port-level temporal checks for asn_tlb, attached by bind.
// Assumes: synchronous active-low reset; all checks are off while in reset.
module tlb_checker #(
    parameter int ENTRIES    = 48,
    parameter int VA_W       = 43,
    parameter int PAGE_SHIFT = 13,
    parameter int ASN_W      = 8,
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VPN_W-1:0] lk_vpn,
    input logic [ASN_W-1:0] lk_asn,
    input logic             lk_hit,
    input logic             ins_en,
    input logic [VA_W-1:0]  ins_vaddr,
    input logic [ASN_W-1:0] ins_asn,
    input logic             fl_all,
    input logic             fl_proc,
    input logic             fl_addr,
    input logic             vic_adv,
    input logic [IDX_W-1:0] vic_ptr,
    input logic             vic_valid
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic any_fl;
    assign any_fl = fl_all || fl_proc || fl_addr;

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vic_ptr <= LAST) else $error("pointer out of range"); // R8

    AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_fl && (ins_en || vic_adv)) |=>
            (vic_ptr == (($past(vic_ptr) == LAST) ? '0 : $past(vic_ptr) + 1'b1)))
        else $error("pointer step wrong"); // R8

    AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_fl && !ins_en && !vic_adv) |=> $stable(vic_ptr))
        else $error("pointer moved while idle"); // R7

    AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> (vic_ptr == '0 && !vic_valid && !lk_hit))
        else $error("clear-all left state"); // R4

    AST_FLUSH_BLOCKS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (any_fl && !fl_all) |=> $stable(vic_ptr))
        else $error("pointer moved during flush"); // R10

    AST_INSERT_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !any_fl) |=>
            (!(lk_vpn == $past(ins_vaddr[VA_W-1:PAGE_SHIFT]) &&
               lk_asn == $past(ins_asn)) || lk_hit))
        else $error("inserted entry not found"); // R3

endmodule

bind asn_tlb tlb_checker #(
    .ENTRIES    (ENTRIES),
    .VA_W       (VA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ASN_W      (ASN_W)
) u_tlb_checker (.*);

// File: tb/asn_tlb_test.sv
module asn_tlb_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 6;
    localparam int VA_W       = 20;
    localparam int PAGE_SHIFT = 8;
    localparam int PPN_W      = 10;
    localparam int ASN_W      = 4;
    localparam int MODES      = 4;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int IDX_W      = $clog2(ENTRIES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASN_W-1:0] lk_asn = '0;
    logic lk_hit, lk_fault_rd, lk_fault_wr, lk_global;
    logic [IDX_W-1:0] lk_idx;
    logic [PPN_W-1:0] lk_ppn;
    logic [MODES-1:0] lk_rd_en, lk_wr_en;
    logic ins_en = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
    logic [VA_W-1:0] ins_vaddr = '0;
    logic [PPN_W-1:0] ins_ppn = '0;
    logic [ASN_W-1:0] ins_asn = '0;
    logic [MODES-1:0] ins_rd_en = '0, ins_wr_en = '0;
    logic fl_all = 0, fl_proc = 0, fl_addr = 0, vic_adv = 0;
    logic [VA_W-1:0] fl_vaddr = '0;
    logic [ASN_W-1:0] fl_asn = '0;
    logic [IDX_W-1:0] vic_ptr;
    logic vic_valid, vic_global;
    logic [VPN_W-1:0] vic_vpn;
    logic [PPN_W-1:0] vic_ppn;
    logic [ASN_W-1:0] vic_asn;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference model state
    bit             m_valid [ENTRIES];
    int             m_tag   [ENTRIES];
    int             m_ppn   [ENTRIES];
    int             m_asn   [ENTRIES];
    bit             m_glob  [ENTRIES];
    int             m_rd    [ENTRIES];
    int             m_wr    [ENTRIES];
    bit             m_frd   [ENTRIES];
    bit             m_fwr   [ENTRIES];
    int             m_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asn_tlb #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT),
              .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) uut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_match(input int e, input int vpn, input int asn);
        return m_valid[e] && m_tag[e] == vpn && (m_glob[e] || m_asn[e] == asn);
    endfunction

    task automatic m_clear();
        for (int e = 0; e < ENTRIES; e++) begin
            m_valid[e] = 0; m_tag[e] = 0; m_ppn[e] = 0; m_asn[e] = 0; m_glob[e] = 0;
            m_rd[e] = 0; m_wr[e] = 0; m_frd[e] = 0; m_fwr[e] = 0;
        end
    endtask

    // Apply one clock edge of the requirements to the model.
    task automatic m_edge();
        if (!rst_n || fl_all) begin
            m_clear();
            m_ptr = 0;
        end else if (fl_proc || fl_addr) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if ((fl_proc && !m_glob[e]) ||
                    (fl_addr && m_match(e, int'(fl_vaddr >> PAGE_SHIFT), int'(fl_asn))))
                    m_valid[e] = 0;
            end
        end else if (ins_en) begin
            m_valid[m_ptr] = 1; m_tag[m_ptr] = int'(ins_vaddr >> PAGE_SHIFT);
            m_ppn[m_ptr] = int'(ins_ppn); m_asn[m_ptr] = int'(ins_asn);
            m_glob[m_ptr] = ins_global; m_rd[m_ptr] = int'(ins_rd_en);
            m_wr[m_ptr] = int'(ins_wr_en); m_frd[m_ptr] = ins_fault_rd;
            m_fwr[m_ptr] = ins_fault_wr;
            m_ptr = (m_ptr == ENTRIES - 1) ? 0 : m_ptr + 1;
        end else if (vic_adv) begin
            m_ptr = (m_ptr == ENTRIES - 1) ? 0 : m_ptr + 1;
        end
    endtask

    // Compare every output with the model for the current lookup inputs.
    task automatic compare_all();
        int w = -1;
        longint exp_lk, act_lk, exp_v, act_v;
        for (int e = ENTRIES - 1; e >= 0; e--)
            if (m_match(e, int'(lk_vpn), int'(lk_asn))) w = e;
        if (w < 0) exp_lk = 0;
        else exp_lk = {1'b1, IDX_W'(w), PPN_W'(m_ppn[w]), MODES'(m_rd[w]),
                       MODES'(m_wr[w]), m_frd[w], m_fwr[w], m_glob[w]};
        act_lk = {lk_hit, lk_idx, lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd,
                  lk_fault_wr, lk_global};
        chk("R2 lookup", act_lk, exp_lk);
        exp_v = {IDX_W'(m_ptr), m_valid[m_ptr], VPN_W'(m_tag[m_ptr]),
                 PPN_W'(m_ppn[m_ptr]), ASN_W'(m_asn[m_ptr]), m_glob[m_ptr]};
        act_v = {vic_ptr, vic_valid, vic_vpn, vic_ppn, vic_asn, vic_global};
        chk("R7 victim", act_v, exp_v);
    endtask

    task automatic tick();
        @(posedge clk);
        m_edge();
        #1;
        compare_all();
        ins_en = 0; fl_all = 0; fl_proc = 0; fl_addr = 0; vic_adv = 0;
    endtask

    task automatic probe(input int vpn, input int asn);
        lk_vpn = VPN_W'(vpn); lk_asn = ASN_W'(asn);
        #1;
    endtask

    task automatic set_ins(input int vpn, input int asn, input bit g, input int ppn);
        ins_en = 1; ins_vaddr = {VPN_W'(vpn), PAGE_SHIFT'(8'h5a)};
        ins_asn = ASN_W'(asn); ins_global = g; ins_ppn = PPN_W'(ppn);
        ins_rd_en = MODES'(ppn); ins_wr_en = MODES'(ppn >> 4);
        ins_fault_rd = ppn[0]; ins_fault_wr = ppn[1];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_clear();
        repeat (3) begin @(posedge clk); m_edge(); end
        #1;
        rst_n = 1;
        // R1: reset state
        probe(5, 1);
        chk("R1 hit", lk_hit, 0);
        chk("R1 ptr", vic_ptr, 0);
        chk("R1 vic_valid", vic_valid, 0);

        set_ins(12'h012, 1, 0, 10'h101); tick();
        probe(12'h012, 1);
        chk("R3 hit", lk_hit, 1);
        chk("R3 ppn", lk_ppn, 10'h101);
        chk("R3 ptr", vic_ptr, 1);
        probe(12'h012, 2);
        chk("R2 asn mismatch", lk_hit, 0);

        set_ins(12'h034, 3, 1, 10'h202); tick();
        probe(12'h034, 0);
        chk("R2 global hit", lk_ppn, 10'h202);

        set_ins(12'h012, 1, 1, 10'h303); tick();
        probe(12'h012, 1);
        chk("R9 lowest idx", lk_idx, 0);
        probe(12'h012, 3);
        chk("R9 global idx", lk_idx, 2);

        vic_adv = 1; tick();
        chk("R7 advance", vic_ptr, 4);
        tick();
        chk("R7 hold", vic_ptr, 4);

        // R10 and R6: address flush with simultaneous insert
        fl_addr = 1; fl_vaddr = {12'h012, 8'h33}; fl_asn = 1;
        set_ins(12'h099, 1, 0, 10'h0ff); tick();
        probe(12'h012, 1);
        chk("R6 asn slot gone", lk_hit, 0);
        probe(12'h012, 3);
        chk("R6 global slot gone", lk_hit, 0);
        probe(12'h099, 1);
        chk("R10 insert dropped", lk_hit, 0);
        chk("R10 ptr held", vic_ptr, 4);
        probe(12'h034, 3);
        chk("R6 other kept", lk_hit, 1);

        set_ins(12'h055, 2, 0, 10'h011); tick();
        set_ins(12'h066, 2, 0, 10'h022); tick();
        chk("R8 wrap", vic_ptr, 0);

        fl_proc = 1; tick();
        probe(12'h034, 7);
        chk("R5 global kept", lk_idx, 1);
        probe(12'h055, 2);
        chk("R5 private gone", lk_hit, 0);

        set_ins(12'h077, 1, 0, 10'h044); tick();
        fl_proc = 1; fl_addr = 1; fl_vaddr = {12'h034, 8'h00}; fl_asn = 9; tick();
        probe(12'h077, 1);
        chk("R11 proc part", lk_hit, 0);
        probe(12'h034, 0);
        chk("R11 addr part", lk_hit, 0);

        set_ins(12'h088, 1, 1, 10'h155); tick();
        vic_adv = 1; tick();
        fl_all = 1; fl_proc = 1; set_ins(12'h0aa, 1, 1, 10'h1aa); tick();
        probe(12'h088, 1);
        chk("R4 cleared", lk_hit, 0);
        chk("R4 ptr zero", vic_ptr, 0);
        chk("R4 victim invalid", vic_valid, 0);
        probe(12'h0aa, 1);
        chk("R10 clear-all beats insert", lk_hit, 0);

        // Random mix, model compared on every clock
        for (int c = 0; c < 3000; c++) begin
            int r = $urandom_range(0, 99);
            fl_all  = (r < 2);
            fl_proc = (r >= 2 && r < 6);
            fl_addr = (r >= 5 && r < 12);
            fl_vaddr = {VPN_W'($urandom_range(0, 7)), PAGE_SHIFT'($urandom)};
            fl_asn = ASN_W'($urandom_range(0, 3));
            if ($urandom_range(0, 99) < 45)
                set_ins($urandom_range(0, 7), $urandom_range(0, 3),
                        ($urandom_range(0, 3) == 0), $urandom_range(0, 1023));
            vic_adv = ($urandom_range(0, 4) == 0);
            lk_vpn = VPN_W'($urandom_range(0, 7));
            lk_asn = ASN_W'($urandom_range(0, 3));
            tick();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule